// File: doc/BRIEF.md
# 64-bit System Timer with Alarms

This block holds a free-running 64-bit time count that advances by one on every cycle in which the tick strobe `tick_i` is high and counting is not halted. Software reaches it through a simple 32-bit register bus. The bus has a word address, write data, a write enable and a read enable. Read data shows the addressed register combinationally. `re_i` only qualifies the read side effect.

The time can be loaded in two steps. A write to the low-half register is only staged. A later write to the high-half register loads the full 64-bit value. There are two ways to read the time:

- A pair of latched reads. Reading the low half captures the high half into a holding register, and the latched high read returns that captured value.
- Raw reads of either half, which have no side effects.

Four alarms each hold a 32-bit target that is compared with the low 32 bits of time. Writing a target also arms its alarm. On a match while armed, the alarm raises its raw interrupt bit and disarms itself. The interrupt path has raw, enable, force and status bits per alarm, and one interrupt line per alarm follows status. Counting stops while a software pause bit is set. It also stops while the debug input of a processor is active and that processor's debug-pause bit is enabled.

Top module: `sys_timer`

Word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | time low stage | write only |
| 1 | time high commit | write only |
| 2 | latched low | read only |
| 3 | latched high | read only |
| 4 | raw low | read only |
| 5 | raw high | read only |
| 6 | pause, bit 0 | read/write |
| 7 | debug mask, bits 2:1 | read/write |
| 8 | armed | read/write |
| 9 | raw interrupt | read/write |
| 10 | interrupt enable | read/write |
| 11 | interrupt force | read/write |
| 12 | interrupt status | read only |
| 16+i | alarm i target | read/write |

## Requirements
- R1: After reset the time is 0, the armed, raw, enable, force and pause registers read 0, and the debug mask register (address 7) reads 6.
- R2: The time increments by exactly 1 on each clock where `tick_i` is 1 and counting is not halted.
- R3: While pause bit 0 (address 6) is 1, the time does not change on ticks.
- R4: The time does not change while `dbg_i[0]` is 1 with mask bit 1 set, or while `dbg_i[1]` is 1 with mask bit 2 set. With both mask bits 0, the debug inputs have no effect.
- R5: A write to address 0 only stages the low half and leaves the time unchanged. A write to address 1 loads {written data, staged low} into the time.
- R6: Reads of addresses 4 and 5 return the live halves and have no side effect. A read of address 2 returns the live low half and captures the high half, which address 3 then returns even after the time changes.
- R7: A write to alarm address 16+i stores the target, which reads back, and sets armed bit i.
- R8: When armed alarm i has a target equal to time[31:0], raw bit i is set and armed bit i is cleared on the next clock. Time bits 63:32 are ignored in the compare.
- R9: Writing a 1 to armed bit i disarms alarm i, and that alarm then raises no interrupt when time reaches its target.
- R10: Writing a 1 to raw interrupt bit i clears it.
- R11: Status (address 12) and `irq_o` equal (raw AND enable) OR force, bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-advance strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable (qualifies read side effects) |
| rdata_o | output | 32 | Read data of addressed register |
| dbg_i | input | 2 | Debug-active flags of processors 0 and 1 |
| irq_o | output | 4 | Interrupt line per alarm |

## Verification
On every cycle, the assertions check the increment-by-one rule, the halt under pause and under enabled debug, arming on a target write, self-disarm on a match, setting of raw bits by a match, and clearing by a write of 1. Other behaviours are shown only by the bench's scenarios:

- the staged low write and the latched-read coherence of the two halves;
- the reset values;
- the fact that the upper time bits are ignored in the compare;
- the silence of an alarm after a software disarm;
- the full masking and forcing of interrupt status.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_LO_STAGE  = 5'd0;
  localparam addr_t A_HI_COMMIT = 5'd1;
  localparam addr_t A_LAT_LO    = 5'd2;
  localparam addr_t A_LAT_HI    = 5'd3;
  localparam addr_t A_RAW_LO    = 5'd4;
  localparam addr_t A_RAW_HI    = 5'd5;
  localparam addr_t A_PAUSE     = 5'd6;
  localparam addr_t A_DBG_MASK  = 5'd7;
  localparam addr_t A_ARMED     = 5'd8;
  localparam addr_t A_IRQ_RAW   = 5'd9;
  localparam addr_t A_IRQ_EN    = 5'd10;
  localparam addr_t A_IRQ_FORCE = 5'd11;
  localparam addr_t A_IRQ_STAT  = 5'd12;
  localparam int    ALARM_BASE  = 16;
endpackage

// File: rtl/sys_timer_count.sv
module sys_timer_count #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATA_W-1:0] hold_o
);
  logic [TIME_W-1:0] time_q;
  logic [DATA_W-1:0] stage_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      if (lo_wr_i) stage_q <= wdata_i;
      if (hi_wr_i)     time_q <= {wdata_i, stage_q};
      else if (inc_i)  time_q <= time_q + TIME_W'(1);
      if (cap_i) hold_q <= time_q[TIME_W-1:DATA_W];
    end
  end

  assign time_o = time_q;
  assign hold_o = hold_q;

  AST_TICK_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !hi_wr_i |=> time_q == $past(time_q) + TIME_W'(1)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !hi_wr_i |=> $stable(time_q)); // R3
  AST_LO_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i && !hi_wr_i && !inc_i |=> $stable(time_q)); // R5
endmodule

// File: rtl/sys_timer_alarm.sv
module sys_timer_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] now_lo_i,
  output logic [DATA_W-1:0] target_o,
  output logic              armed_o,
  output logic              fire_o
);
  logic [DATA_W-1:0] target_q;
  logic              armed_q;

  // target write wins over match and disarm in the same cycle
  assign fire_o = armed_q && (target_q == now_lo_i) && !wr_i && !disarm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (wr_i) begin
      target_q <= wdata_i;
      armed_q  <= 1'b1;
    end else if (disarm_i || fire_o) begin
      armed_q  <= 1'b0;
    end
  end

  assign target_o = target_q;
  assign armed_o  = armed_q;

  AST_ARM_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> armed_q && target_q == $past(wdata_i)); // R7
  AST_FIRE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q); // R8
  AST_SW_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i && !wr_i |=> !armed_q); // R9
endmodule

// File: rtl/sys_timer_irq.sv
module sys_timer_irq #(
  parameter int N_ALARM = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ALARM-1:0] fire_i,
  input  logic               raw_wr_i,
  input  logic               en_wr_i,
  input  logic               force_wr_i,
  input  logic [N_ALARM-1:0] wdata_i,
  output logic [N_ALARM-1:0] raw_o,
  output logic [N_ALARM-1:0] en_o,
  output logic [N_ALARM-1:0] force_o,
  output logic [N_ALARM-1:0] status_o
);
  logic [N_ALARM-1:0] raw_q, en_q, force_q, clr;

  assign clr = raw_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q   <= '0;
      en_q    <= '0;
      force_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | fire_i; // set beats clear
      if (en_wr_i)    en_q    <= wdata_i;
      if (force_wr_i) force_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign force_o  = force_q;
  assign status_o = (raw_q & en_q) | force_q;

  AST_FIRE_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |fire_i |=> (raw_q & $past(fire_i)) == $past(fire_i)); // R8
  AST_W1C_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_wr_i && |(wdata_i & ~fire_i) |=> (raw_q & $past(wdata_i & ~fire_i)) == '0); // R10
endmodule

// File: rtl/sys_timer.sv
module sys_timer
  import sys_timer_pkg::*;
#(
  parameter int N_ALARM = 4,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [1:0]         dbg_i,
  output logic [N_ALARM-1:0] irq_o
);
  logic               pause_q;
  logic [1:0]         dbg_mask_q;   // bit k enables halt on dbg_i[k]
  logic               halt, inc, hi_wr;
  logic [TIME_W-1:0]  time_now;
  logic [DATA_W-1:0]  hold_hi;
  logic [DATA_W-1:0]  target [N_ALARM];
  logic [N_ALARM-1:0] armed, fire, alm_wr, raw, en, frc, stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q    <= 1'b0;
      dbg_mask_q <= 2'b11;
    end else if (we_i) begin
      if (addr_i == A_PAUSE)    pause_q    <= wdata_i[0];
      if (addr_i == A_DBG_MASK) dbg_mask_q <= wdata_i[2:1];
    end
  end

  assign halt  = pause_q || |(dbg_i & dbg_mask_q);
  assign inc   = tick_i && !halt;
  assign hi_wr = we_i && addr_i == A_HI_COMMIT;

  sys_timer_count #(.DATA_W(DATA_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .lo_wr_i (we_i && addr_i == A_LO_STAGE),
    .hi_wr_i (hi_wr),
    .cap_i   (re_i && addr_i == A_LAT_LO),
    .wdata_i (wdata_i),
    .time_o  (time_now),
    .hold_o  (hold_hi)
  );

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
    assign alm_wr[i] = we_i && addr_i == addr_t'(ALARM_BASE + i);
    sys_timer_alarm #(.DATA_W(DATA_W)) u_alarm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (alm_wr[i]),
      .disarm_i (we_i && addr_i == A_ARMED && wdata_i[i]),
      .wdata_i  (wdata_i),
      .now_lo_i (time_now[DATA_W-1:0]),
      .target_o (target[i]),
      .armed_o  (armed[i]),
      .fire_o   (fire[i])
    );
  end

  sys_timer_irq #(.N_ALARM(N_ALARM)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .raw_wr_i   (we_i && addr_i == A_IRQ_RAW),
    .en_wr_i    (we_i && addr_i == A_IRQ_EN),
    .force_wr_i (we_i && addr_i == A_IRQ_FORCE),
    .wdata_i    (wdata_i[N_ALARM-1:0]),
    .raw_o      (raw),
    .en_o       (en),
    .force_o    (frc),
    .status_o   (stat)
  );

  assign irq_o = stat;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LAT_LO, A_RAW_LO: rdata_o = time_now[DATA_W-1:0];
      A_LAT_HI:           rdata_o = hold_hi;
      A_RAW_HI:           rdata_o = time_now[TIME_W-1:DATA_W];
      A_PAUSE:            rdata_o = {{(DATA_W-1){1'b0}}, pause_q};
      A_DBG_MASK:         rdata_o = {{(DATA_W-3){1'b0}}, dbg_mask_q, 1'b0};
      A_ARMED:            rdata_o = {{(DATA_W-N_ALARM){1'b0}}, armed};
      A_IRQ_RAW:          rdata_o = {{(DATA_W-N_ALARM){1'b0}}, raw};
      A_IRQ_EN:           rdata_o = {{(DATA_W-N_ALARM){1'b0}}, en};
      A_IRQ_FORCE:        rdata_o = {{(DATA_W-N_ALARM){1'b0}}, frc};
      A_IRQ_STAT:         rdata_o = {{(DATA_W-N_ALARM){1'b0}}, stat};
      default: begin
        for (int i = 0; i < N_ALARM; i++)
          if (addr_i == addr_t'(ALARM_BASE + i)) rdata_o = target[i];
      end
    endcase
  end

  AST_DBG_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(dbg_i & dbg_mask_q) && !hi_wr |=> $stable(time_now)); // R4
  AST_PAUSE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_q && !hi_wr |=> $stable(time_now)); // R3
endmodule

// File: tb/sys_timer_tb.sv
module sys_timer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 0, re = 0;
  logic [31:0] rdata;
  logic [1:0]  dbg = '0;
  logic [3:0]  irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sys_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata),
    .dbg_i(dbg), .irq_o(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [4:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd7,  32'h6,  8'd1},  // R1 debug mask reset
    '{1'b1, 5'd4,  32'h0,  8'd1},  // R1 time zero
    '{1'b1, 5'd8,  32'h0,  8'd1},  // R1 armed zero
    '{1'b1, 5'd6,  32'h0,  8'd1},  // R1 pause zero
    '{1'b0, 5'd0,  32'h10, 8'd5},
    '{1'b1, 5'd4,  32'h0,  8'd5},  // R5 staged only
    '{1'b0, 5'd1,  32'h2,  8'd5},
    '{1'b1, 5'd4,  32'h10, 8'd5},  // R5 commit low
    '{1'b1, 5'd5,  32'h2,  8'd5},  // R5 commit high
    '{1'b1, 5'd2,  32'h10, 8'd6},  // R6 capture
    '{1'b0, 5'd0,  32'h0,  8'd6},
    '{1'b0, 5'd1,  32'h5,  8'd6},
    '{1'b1, 5'd3,  32'h2,  8'd6},  // R6 held high
    '{1'b1, 5'd5,  32'h5,  8'd6},  // R6 live high
    '{1'b1, 5'd2,  32'h0,  8'd6}   // R6 recapture
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1; #1 v = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic rchk(input int req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(1, {28'd0, irq}, 32'h0); // R1 irq idle

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rchk(int'(VEC[i].req), VEC[i].a, VEC[i].d);
      else wr(VEC[i].a, VEC[i].d);
    end

    // R2 counting
    wr(5'd0, 0); wr(5'd1, 0);
    ticks(5);
    rchk(2, 5'd4, 32'd5);
    // R3 pause
    wr(5'd6, 1); ticks(4);
    rchk(3, 5'd4, 32'd5);
    wr(5'd6, 0);
    // R4 debug halt and mask
    dbg = 2'b01; ticks(3);
    rchk(4, 5'd4, 32'd5);
    wr(5'd7, 0); ticks(3);
    rchk(4, 5'd4, 32'd8);
    wr(5'd7, 6); dbg = 2'b10; ticks(2);
    rchk(4, 5'd4, 32'd8);
    dbg = 2'b00;

    // R7 arm, R8 fire
    wr(5'd16, 32'd12);
    rchk(7, 5'd8, 32'h1);
    rchk(7, 5'd16, 32'd12);
    ticks(3);
    rchk(8, 5'd9, 32'h0);
    rchk(8, 5'd8, 32'h1);
    ticks(1); idle(2);
    rchk(8, 5'd9, 32'h1);
    rchk(8, 5'd8, 32'h0);
    // R11 masking and forcing
    chk(11, {28'd0, irq}, 32'h0);
    wr(5'd10, 1);
    #1 chk(11, {28'd0, irq}, 32'h1);
    rchk(11, 5'd12, 32'h1);
    // R10 clear
    wr(5'd9, 1);
    rchk(10, 5'd9, 32'h0);
    #1 chk(11, {28'd0, irq}, 32'h0);
    wr(5'd11, 2);
    rchk(11, 5'd12, 32'h2);
    #1 chk(11, {28'd0, irq}, 32'h2);
    wr(5'd11, 0);

    // R8 upper bits ignored
    wr(5'd0, 32'd20); wr(5'd1, 32'd7);
    wr(5'd17, 32'd25);
    ticks(5); idle(2);
    rchk(8, 5'd9, 32'h2);
    rchk(8, 5'd8, 32'h0);
    #1 chk(11, {28'd0, irq}, 32'h0);
    wr(5'd9, 2);

    // R9 disarm
    wr(5'd18, 32'd1000);
    rchk(9, 5'd8, 32'h4);
    wr(5'd8, 4);
    rchk(9, 5'd8, 32'h0);
    wr(5'd0, 32'd1000); wr(5'd1, 0);
    idle(3);
    rchk(9, 5'd4, 32'd1000);
    rchk(9, 5'd9, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule